// File: doc/BRIEF.md
# Decimation Cycle Sequencer

This block produces the timing backbone for a decimate-by-64 filter placed after an oversampling modulator. A single 14-bit cycle counter advances on every rising edge of the master clock. Its six least significant bits pace the decimation: each time they roll over, one output word period has ended. Its most significant bit marks the end of a settling window of 8192 clocks that follows any restart of the sequence.

Several restart sources exist: an external sync input, a synchronous reset command, a calibration start, an instability detection, and the first frame-sync seen after power-on. Each of them holds the counter at zero and drops the settled indication. Only the reset command also asks the surrounding logic to clear the offset and gain calibration registers. A sync does not. The data-valid output follows the settled flag in serial mode. In parallel mode it waits one further output period, so that a settled word has been loaded into the output register.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `decseq_top`

## Requirements
- R1: While no restart source is sampled high, `cyc_count` increases by one on every rising clock edge and wraps from 16383 to 0.
- R2: `conv_done` is high for exactly one cycle, in the cycle where the low 6 bits of `cyc_count` read 0 after having read 63. It never appears on two consecutive cycles.
- R3: `settled` rises in the cycle in which `cyc_count` first reads 8192 after a restart. It then stays high, including across the counter wrap, until the next restart.
- R4: A rising edge that samples `sync_in` high makes `cyc_count` read 0 and clears `settled`. The counter stays at 0 while `sync_in` stays high, and reads 1 after the first edge that samples `sync_in` low. A one-cycle pulse therefore releases the counter on the very next edge.
- R5: A sync (or any restart other than the reset command) leaves `cal_clr_req` low.
- R6: `reset_cmd` restarts the sequence exactly as sync does. `cal_clr_req` is high in each cycle that follows an edge that sampled `reset_cmd` high, and low otherwise.
- R7: `cal_start` and `instab_det` each restart the sequence in the same way as sync.
- R8: `frame_sync` restarts the sequence only the first time it is sampled high after power-on reset. Later pulses have no effect on the counter.
- R9: `data_ok` equals `settled` when `par_mode` is 0. When `par_mode` is 1, it rises 64 clocks after `settled` (when `cyc_count` reads 8256) and is cleared by any restart.
- R10: While `por_n` is low, `cyc_count`, `conv_done`, `settled` and `data_ok` are 0 and `cal_clr_req` is 1. The first frame-sync record is cleared as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sync_in | input | 1 | External synchronization request |
| reset_cmd | input | 1 | Synchronous reset command; also requests calibration clear |
| cal_start | input | 1 | Calibration sequence start |
| instab_det | input | 1 | Modulator instability detected |
| frame_sync | input | 1 | Frame sync; only the first after power-on restarts |
| par_mode | input | 1 | 1 = parallel output timing, 0 = serial |
| cyc_count | output | 14 | Current cycle counter value |
| conv_done | output | 1 | One-cycle strobe at each decimation period boundary |
| settled | output | 1 | Settling window has elapsed since the last restart |
| data_ok | output | 1 | Output data may be treated as valid |
| cal_clr_req | output | 1 | Request to clear offset and gain calibration registers |

## Verification
The embedded assertions check the following on every clock:
- the hold-to-zero and increment-by-one rule of the counter;
- that the decimation strobe lines up with low bits of zero and never repeats on the next cycle;
- that the settled flag rises exactly at 8192 and stays set while no restart occurs;
- that the parallel ready flag implies settled;
- that the calibration clear follows only the reset command.

Other behaviour needs the bench's scenarios, which compare every output against a behavioural model:
- that only the first frame-sync restarts;
- the exact 64-clock extra delay in parallel mode;
- the release timing of one-cycle and multi-cycle sync pulses;
- settled staying set across the 14-bit wrap.

// File: rtl/decseq_pkg.sv
package decseq_pkg;

  // Collected restart sources, sampled on the rising clock edge
  typedef struct packed {
    logic sync;
    logic rst;
    logic cal;
    logic inst;
    logic fs;
  } restart_src_t;

endpackage

// File: rtl/decseq_restart.sv
module decseq_restart
  import decseq_pkg::*;
(
  input  logic         clk,
  input  logic         por_n,
  input  restart_src_t src_i,
  output logic         hold_o,
  output logic         cal_clr_o
);

  logic fs_seen_q;

  // Any restart source forces the sequence back to zero
  always_comb begin
    hold_o = src_i.sync | src_i.rst | src_i.cal | src_i.inst |
             (src_i.fs & ~fs_seen_q);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fs_seen_q <= 1'b0;
      cal_clr_o <= 1'b1;
    end else begin
      fs_seen_q <= fs_seen_q | src_i.fs;
      cal_clr_o <= src_i.rst;
    end
  end

  // R6
  cal_clr_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    src_i.rst |=> cal_clr_o);

  // R5
  cal_clr_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !src_i.rst |=> !cal_clr_o);

  // R8
  fs_once_chk: assert property (@(posedge clk) disable iff (!por_n)
    fs_seen_q |=> fs_seen_q);

endmodule

// File: rtl/decseq_counter.sv
module decseq_counter #(
  parameter int CNT_W    = 14,
  parameter int DEC_LOG2 = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             settle_hit_o,
  output logic             conv_done_o
);

  localparam logic [DEC_LOG2-1:0] LOW_LAST    = '1;
  localparam logic [CNT_W-1:0]    SETTLE_LAST = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic [CNT_W-1:0] cnt_q;

  // Decimation period ends when the low field is at its last value
  always_comb begin
    wrap_o       = ~hold_i & (cnt_q[DEC_LOG2-1:0] == LOW_LAST);
    settle_hit_o = ~hold_i & (cnt_q == SETTLE_LAST);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q       <= '0;
      conv_done_o <= 1'b0;
    end else if (hold_i) begin
      cnt_q       <= '0;
      conv_done_o <= 1'b0;
    end else begin
      cnt_q       <= cnt_q + CNT_W'(1);
      conv_done_o <= wrap_o;
    end
  end

  assign cnt_o = cnt_q;

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold_i |=> (cnt_q == '0));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hold_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2
  done_align_chk: assert property (@(posedge clk) disable iff (!por_n)
    conv_done_o |-> (cnt_q[DEC_LOG2-1:0] == '0));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    conv_done_o |=> !conv_done_o);

endmodule

// File: rtl/decseq_settle.sv
module decseq_settle (
  input  logic clk,
  input  logic por_n,
  input  logic hold_i,
  input  logic wrap_i,
  input  logic settle_hit_i,
  input  logic par_mode_i,
  output logic settled_o,
  output logic data_ok_o
);

  logic settled_q;
  logic prdy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      settled_q <= 1'b0;
      prdy_q    <= 1'b0;
    end else if (hold_i) begin
      settled_q <= 1'b0;
      prdy_q    <= 1'b0;
    end else begin
      settled_q <= settled_q | settle_hit_i;
      // Parallel ready waits for the first full period after settling
      prdy_q    <= prdy_q | (settled_q & wrap_i);
    end
  end

  always_comb begin
    settled_o = settled_q;
    data_ok_o = par_mode_i ? prdy_q : settled_q;
  end

  // R9
  prdy_needs_settled_chk: assert property (@(posedge clk) disable iff (!por_n)
    prdy_q |-> settled_q);

  // R3
  settled_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (settled_q && !hold_i) |=> settled_q);

  // R3
  settled_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold_i |=> !settled_q);

endmodule

// File: rtl/decseq_top.sv
module decseq_top
  import decseq_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int DEC_LOG2 = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sync_in,
  input  logic             reset_cmd,
  input  logic             cal_start,
  input  logic             instab_det,
  input  logic             frame_sync,
  input  logic             par_mode,
  output logic [CNT_W-1:0] cyc_count,
  output logic             conv_done,
  output logic             settled,
  output logic             data_ok,
  output logic             cal_clr_req
);

  localparam logic [CNT_W-1:0] SETTLE_AT = CNT_W'(1 << (CNT_W - 1));

  restart_src_t src;
  logic         hold;
  logic         wrap;
  logic         settle_hit;

  always_comb begin
    src.sync = sync_in;
    src.rst  = reset_cmd;
    src.cal  = cal_start;
    src.inst = instab_det;
    src.fs   = frame_sync;
  end

  decseq_restart u_restart (
    .clk       (clk),
    .por_n     (por_n),
    .src_i     (src),
    .hold_o    (hold),
    .cal_clr_o (cal_clr_req)
  );

  decseq_counter #(
    .CNT_W    (CNT_W),
    .DEC_LOG2 (DEC_LOG2)
  ) u_counter (
    .clk          (clk),
    .por_n        (por_n),
    .hold_i       (hold),
    .cnt_o        (cyc_count),
    .wrap_o       (wrap),
    .settle_hit_o (settle_hit),
    .conv_done_o  (conv_done)
  );

  decseq_settle u_settle (
    .clk          (clk),
    .por_n        (por_n),
    .hold_i       (hold),
    .wrap_i       (wrap),
    .settle_hit_i (settle_hit),
    .par_mode_i   (par_mode),
    .settled_o    (settled),
    .data_ok_o    (data_ok)
  );

  // R3
  settle_point_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(settled) |-> (cyc_count == SETTLE_AT));

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sync_in |=> (cyc_count == '0 && !settled && !conv_done));

  // R7
  other_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cal_start || instab_det) |=> (cyc_count == '0 && !data_ok));

endmodule

// File: tb/decseq_top_tb.sv
module decseq_top_tb;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sync_in = 1'b0, reset_cmd = 1'b0, cal_start = 1'b0;
  logic        instab_det = 1'b0, frame_sync = 1'b0, par_mode = 1'b0;
  logic [13:0] cyc_count;
  logic        conv_done, settled, data_ok, cal_clr_req;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_done = 0, m_set = 0, m_prdy = 0, m_cal = 1, m_fs = 0;

  always #2 clk = ~clk;

  decseq_top u_dut (
    .clk(clk), .por_n(por_n), .sync_in(sync_in), .reset_cmd(reset_cmd),
    .cal_start(cal_start), .instab_det(instab_det), .frame_sync(frame_sync),
    .par_mode(par_mode), .cyc_count(cyc_count), .conv_done(conv_done),
    .settled(settled), .data_ok(data_ok), .cal_clr_req(cal_clr_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!por_n) begin
      m_cnt = 0; m_done = 0; m_set = 0; m_prdy = 0; m_cal = 1; m_fs = 0;
    end else begin
      bit restart;
      restart = sync_in || reset_cmd || cal_start || instab_det ||
                (frame_sync && !m_fs);
      if (frame_sync) m_fs = 1;
      m_cal = reset_cmd;
      if (restart) begin
        m_cnt = 0; m_done = 0; m_set = 0; m_prdy = 0;
      end else begin
        m_done = (m_cnt % 64) == 63;
        if (m_set && (m_cnt % 64) == 63) m_prdy = 1;
        if (m_cnt == 8191) m_set = 1;
        m_cnt = (m_cnt + 1) % 16384;
      end
    end
  end

  // compare every cycle, shortly after the edge
  always begin
    @(posedge clk);
    #1;
    chk("R1 cyc_count", int'(cyc_count), m_cnt);
    chk("R2 conv_done", int'(conv_done), int'(m_done));
    chk("R3 settled", int'(settled), int'(m_set));
    chk("R9 data_ok", int'(data_ok), par_mode ? int'(m_prdy) : int'(m_set));
    chk("R6 cal_clr_req", int'(cal_clr_req), int'(m_cal));
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic after_edge;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int keep;
    // R10: power-on state
    step(3);
    chk("R10 count in reset", int'(cyc_count), 0);
    chk("R10 cal_clr in reset", int'(cal_clr_req), 1);
    chk("R10 settled in reset", int'(settled), 0);
    por_n = 1'b1;
    // R1/R3: serial run through settling
    step(8300);
    chk("R3 settled after window", int'(settled), 1);
    chk("R9 serial data_ok", int'(data_ok), 1);
    // R4/R5: one-cycle sync pulse in parallel mode
    par_mode = 1'b1;
    sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    after_edge();
    chk("R4 released after pulse", int'(cyc_count), 1);
    chk("R5 sync no cal clear", int'(cal_clr_req), 0);
    step(8300);
    chk("R9 parallel ready", int'(data_ok), 1);
    // R4: sync held several cycles
    @(negedge clk); sync_in = 1'b1;
    step(5);
    chk("R4 held at zero", int'(cyc_count), 0);
    sync_in = 1'b0;
    step(100);
    // R8: first frame sync restarts, the second does not
    frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    chk("R8 first fs restarts", int'(cyc_count), 0);
    step(50);
    keep = int'(cyc_count);
    frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    chk("R8 later fs ignored", int'(cyc_count), keep + 1);
    // R6: reset command
    step(20);
    reset_cmd = 1'b1;
    @(negedge clk); reset_cmd = 1'b0;
    chk("R6 cal clear raised", int'(cal_clr_req), 1);
    chk("R6 count restarted", int'(cyc_count), 0);
    step(2);
    chk("R6 cal clear dropped", int'(cal_clr_req), 0);
    // R7: calibration start and instability
    step(30);
    cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
    chk("R7 cal_start restarts", int'(cyc_count), 0);
    step(40);
    instab_det = 1'b1;
    step(3);
    instab_det = 1'b0;
    chk("R7 instab restarts", int'(cyc_count), 0);
    // R1/R3: run past the 14-bit wrap, serial mode
    par_mode = 1'b0;
    step(16500);
    chk("R3 sticky across wrap", int'(settled), 1);
    step(2);
    finish_up();
  end

endmodule